// File: doc/BRIEF.md
# Timer Interrupt Status and Router

This block sits between a bank of timer channels and the interrupt fabric. Each channel raises a one-cycle expiry strobe. The block turns that strobe into one of two things. It can assert one of 32 interrupt lines, or it can post a 32-bit message write. The choice depends on the channel's configuration. A shared status vector records pending level-type interrupts, and software clears it by writing ones to it.

In a legacy replacement mode, the first two channels ignore their configured line and use fixed lines 0 and 8. An external real-time-clock interrupt normally passes through to line 8. In legacy mode that path is cut. When legacy mode ends, the path resumes with the level stored most recently.

A channel in message mode holds a pending flag until the write port acknowledges it. Further expiries on that channel before the acknowledge fold into the one pending write. When several channels are pending, the lowest-numbered channel is presented first.

Top module: `tmr_irq_router`

## Requirements
- R1: With legacy mode off, an expiry on an enabled, line-mode channel drives `irq_out[route]`, where `route` is that channel's 5-bit field in `ch_route` (bits `5*k+4:5*k`). The line is visible in the cycle after the strobe is sampled.
- R2: With legacy mode on, channel 0 drives line 0 and channel 1 drives line 8, whatever their route fields hold. Channels 2 and up keep their configured route.
- R3: A level channel (`ch_level[k]=1`) sets `sts_rdata[k]`. Its line then stays high until the bit is cleared.
- R4: An edge channel (`ch_level[k]=0`) raises its line for exactly one clock and leaves `sts_rdata[k]` at 0.
- R5: A clock with `sts_wr` high clears every status bit whose `sts_wdata` bit is 1 and lowers the matching lines. Status bits written with 0 are unchanged, and their lines are unchanged.
- R6: If `ch_en[k]` or `glb_en` is low, status bit k is cleared, channel k's line is lowered, and expiries on channel k are ignored.
- R7: With `ch_msg_en[k]=1`, an expiry drives no line and sets no status bit. Instead it raises `msg_req` with `msg_addr` = `ch_msg_dest[64*k+63:64*k+32]` and `msg_data` = `ch_msg_dest[64*k+31:64*k]`.
- R8: A 0-to-1 change of `ch_msg_en[k]` clears status bit k and withdraws channel k's line in the following cycle.
- R9: `msg_req` stays high until a clock with `msg_ack` high. Repeated expiries on a pending channel merge into one write.
- R10: With legacy mode off, `irq_out[8]` follows the registered `rtc_irq_in`. Entering legacy mode removes that contribution, and leaving legacy mode restores it.
- R11: With several channels pending a message, the lowest-numbered channel is presented first. Each acknowledge retires exactly that channel.
- R12: After reset, all lines, all status bits and `msg_req` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| glb_en | input | 1 | Global interrupt enable |
| legacy_en | input | 1 | Legacy replacement routing mode |
| rtc_irq_in | input | 1 | External real-time-clock interrupt level |
| ch_fire | input | N_CH | Per-channel expiry strobes |
| ch_en | input | N_CH | Per-channel interrupt enable |
| ch_level | input | N_CH | 1 = level trigger, 0 = edge trigger |
| ch_msg_en | input | N_CH | Per-channel message-delivery enable |
| ch_route | input | 5*N_CH | Per-channel line index |
| ch_msg_dest | input | 64*N_CH | Per-channel message word: address in high half, data in low half |
| sts_wr | input | 1 | Status write strobe (write-one-to-clear) |
| sts_wdata | input | N_CH | Status write data |
| sts_rdata | output | N_CH | Status vector |
| irq_out | output | 32 | Interrupt lines |
| msg_req | output | 1 | Message write request |
| msg_addr | output | 32 | Message write address |
| msg_data | output | 32 | Message write data |
| msg_ack | input | 1 | Message write acknowledge |

## Verification
The embedded properties check the following every cycle:
- a level expiry always sets its status bit;
- a write-one-to-clear or a disabled channel always empties the status bit;
- an edge pulse never outlives its strobe;
- a message-enable rising edge always withdraws status;
- an unacknowledged request never drops;
- the clock passthrough reaches line 8 whenever legacy mode is off.

Other behaviour is only visible in the bench's scenarios, which compare values across the whole output. These are the exact line chosen under both routing modes, the one-cycle width of an edge pulse, the merge of repeated expiries into a single write, and the lowest-first ordering of several pending writes with their address and data.

// File: rtl/tirq_pkg.sv
package tirq_pkg;
    localparam int LINES   = 32;
    localparam int LINE_W  = 5;
    localparam int WORD_W  = 32;
    localparam int DEST_W  = 2 * WORD_W;

    typedef logic [LINE_W-1:0] line_idx_t;

    localparam line_idx_t LEG_LINE_CH0 = 5'd0;
    localparam line_idx_t RTC_LINE     = 5'd8;

    typedef struct packed {
        logic      active;
        logic      level;
        logic      msg_en;
    } chan_mode_t;

    // Line selection: legacy mode pins channels 0 and 1 to fixed lines.
    function automatic line_idx_t pick_line(input int unsigned ch,
                                            input logic legacy,
                                            input line_idx_t route);
        if (legacy && ch == 0)
            return LEG_LINE_CH0;
        else if (legacy && ch == 1)
            return RTC_LINE;
        else
            return route;
    endfunction
endpackage

// File: rtl/tirq_chan.sv
module tirq_chan
    import tirq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  chan_mode_t mode,
    input  logic       fire,
    input  logic       w1c,
    input  logic       ack_clr,
    output logic       sts,
    output logic       pulse,
    output logic       pend
);
    logic sts_q, pulse_q, pend_q, msg_en_q;
    logic fire_ok, set_lvl, set_edge, msg_rise, clr_any;

    assign fire_ok  = fire & mode.active;
    assign set_lvl  = fire_ok & ~mode.msg_en & mode.level;
    assign set_edge = fire_ok & ~mode.msg_en & ~mode.level;
    assign msg_rise = mode.msg_en & ~msg_en_q;
    assign clr_any  = w1c | ~mode.active | msg_rise | set_edge;

    always_ff @(posedge clk) begin
        if (rst) begin
            sts_q    <= 1'b0;
            pulse_q  <= 1'b0;
            pend_q   <= 1'b0;
            msg_en_q <= 1'b0;
        end else begin
            msg_en_q <= mode.msg_en;
            pulse_q  <= set_edge;
            pend_q   <= (pend_q & ~ack_clr) | (fire_ok & mode.msg_en);
            if (set_lvl)
                sts_q <= 1'b1;
            else if (clr_any)
                sts_q <= 1'b0;
        end
    end

    assign sts   = sts_q;
    assign pulse = pulse_q;
    assign pend  = pend_q;

    p_level_sets_r3: assert property (@(posedge clk) disable iff (rst)
        (fire && mode.active && !mode.msg_en && mode.level) |=> sts_q);
    p_w1c_clears_r5: assert property (@(posedge clk) disable iff (rst)
        (w1c && !fire) |=> !sts_q);
    p_disabled_clears_r6: assert property (@(posedge clk) disable iff (rst)
        !mode.active |=> !sts_q);
    p_pulse_one_clk_r4: assert property (@(posedge clk) disable iff (rst)
        pulse_q |=> (!pulse_q || $past(fire)));
    p_msg_rise_withdraws_r8: assert property (@(posedge clk) disable iff (rst)
        (mode.msg_en && !msg_en_q) |=> !sts_q);
endmodule

// File: rtl/tirq_line_map.sv
module tirq_line_map
    import tirq_pkg::*;
#(
    parameter int N_CH = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   legacy,
    input  logic                   rtc_lvl,
    input  logic [N_CH-1:0]        drive,
    input  logic [N_CH*LINE_W-1:0] route,
    output logic [LINES-1:0]       lines
);
    always_comb begin
        lines = '0;
        for (int i = 0; i < N_CH; i++) begin
            if (drive[i])
                lines[pick_line(i, legacy, route[i*LINE_W +: LINE_W])] = 1'b1;
        end
        if (!legacy && rtc_lvl)
            lines[RTC_LINE] = 1'b1;
    end

    p_rtc_passes_r10: assert property (@(posedge clk) disable iff (rst)
        (!legacy && rtc_lvl) |-> lines[RTC_LINE]);
endmodule

// File: rtl/tirq_msg_arb.sv
module tirq_msg_arb
    import tirq_pkg::*;
#(
    parameter int N_CH = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [N_CH-1:0]        pend,
    input  logic [N_CH*DEST_W-1:0] dest,
    input  logic                   ack,
    output logic                   req,
    output logic [WORD_W-1:0]      addr,
    output logic [WORD_W-1:0]      data,
    output logic [N_CH-1:0]        ack_clr
);
    localparam int SEL_W = (N_CH > 1) ? $clog2(N_CH) : 1;

    logic [SEL_W-1:0] sel;
    logic             found;

    always_comb begin
        sel   = '0;
        found = 1'b0;
        for (int i = 0; i < N_CH; i++) begin
            if (pend[i] && !found) begin
                sel   = i[SEL_W-1:0];
                found = 1'b1;
            end
        end
    end

    assign req  = |pend;
    assign addr = dest[int'(sel)*DEST_W + WORD_W +: WORD_W];
    assign data = dest[int'(sel)*DEST_W +: WORD_W];

    always_comb begin
        ack_clr      = '0;
        ack_clr[sel] = req & ack;
    end

    p_req_holds_r9: assert property (@(posedge clk) disable iff (rst)
        (req && !ack) |=> req);
    p_single_retire_r11: assert property (@(posedge clk) disable iff (rst)
        $countones(ack_clr) <= 1);
endmodule

// File: rtl/tmr_irq_router.sv
module tmr_irq_router
    import tirq_pkg::*;
#(
    parameter int N_CH = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   glb_en,
    input  logic                   legacy_en,
    input  logic                   rtc_irq_in,
    input  logic [N_CH-1:0]        ch_fire,
    input  logic [N_CH-1:0]        ch_en,
    input  logic [N_CH-1:0]        ch_level,
    input  logic [N_CH-1:0]        ch_msg_en,
    input  logic [N_CH*5-1:0]      ch_route,
    input  logic [N_CH*64-1:0]     ch_msg_dest,
    input  logic                   sts_wr,
    input  logic [N_CH-1:0]        sts_wdata,
    output logic [N_CH-1:0]        sts_rdata,
    output logic [31:0]            irq_out,
    output logic                   msg_req,
    output logic [31:0]            msg_addr,
    output logic [31:0]            msg_data,
    input  logic                   msg_ack
);
    logic [N_CH-1:0] sts, pulse, pend, ack_clr, drive;
    logic            rtc_q;

    always_ff @(posedge clk) begin
        if (rst) rtc_q <= 1'b0;
        else     rtc_q <= rtc_irq_in;
    end

    for (genvar k = 0; k < N_CH; k++) begin : g_ch
        chan_mode_t md;
        assign md.active = ch_en[k] & glb_en;
        assign md.level  = ch_level[k];
        assign md.msg_en = ch_msg_en[k];

        tirq_chan u_chan (
            .clk     (clk),
            .rst     (rst),
            .mode    (md),
            .fire    (ch_fire[k]),
            .w1c     (sts_wr & sts_wdata[k]),
            .ack_clr (ack_clr[k]),
            .sts     (sts[k]),
            .pulse   (pulse[k]),
            .pend    (pend[k])
        );
    end

    assign drive     = sts | pulse;
    assign sts_rdata = sts;

    tirq_line_map #(.N_CH(N_CH)) u_map (
        .clk     (clk),
        .rst     (rst),
        .legacy  (legacy_en),
        .rtc_lvl (rtc_q),
        .drive   (drive),
        .route   (ch_route),
        .lines   (irq_out)
    );

    tirq_msg_arb #(.N_CH(N_CH)) u_arb (
        .clk     (clk),
        .rst     (rst),
        .pend    (pend),
        .dest    (ch_msg_dest),
        .ack     (msg_ack),
        .req     (msg_req),
        .addr    (msg_addr),
        .data    (msg_data),
        .ack_clr (ack_clr)
    );
endmodule

// File: tb/sim_tmr_irq_router.sv
module sim_tmr_irq_router;
    localparam int N = 4;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            glb_en = 1'b0, legacy_en = 1'b0, rtc_irq_in = 1'b0;
    logic [N-1:0]    ch_fire = '0, ch_en = '0, ch_level = '0, ch_msg_en = '0;
    logic [N*5-1:0]  ch_route = '0;
    logic [N*64-1:0] ch_msg_dest = '0;
    logic            sts_wr = 1'b0;
    logic [N-1:0]    sts_wdata = '0;
    logic [N-1:0]    sts_rdata;
    logic [31:0]     irq_out, msg_addr, msg_data;
    logic            msg_req, msg_ack = 1'b0;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tmr_irq_router #(.N_CH(N)) u0 (.*);

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // {legacy, channel[1:0], route[4:0], level, expected line[4:0]}
    localparam logic [13:0] VEC [6] = '{
        {1'b0, 2'd0, 5'd3,  1'b1, 5'd3},
        {1'b0, 2'd2, 5'd31, 1'b0, 5'd31},
        {1'b1, 2'd0, 5'd5,  1'b1, 5'd0},
        {1'b1, 2'd1, 5'd20, 1'b0, 5'd8},
        {1'b1, 2'd3, 5'd17, 1'b1, 5'd17},
        {1'b0, 2'd1, 5'd12, 1'b1, 5'd12}
    };

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        step(); step();
        chk("R12 lines in reset", {32'd0, irq_out}, 64'd0);
        rst = 1'b0;
        step();
        chk("R12 status", {60'd0, sts_rdata}, 64'd0);
        chk("R12 lines", {32'd0, irq_out}, 64'd0);
        chk("R12 msg_req", {63'd0, msg_req}, 64'd0);

        glb_en = 1'b1;
        ch_en  = '1;
        for (int e = 0; e < 6; e++) begin
            logic       lg, lv;
            logic [1:0] c;
            logic [4:0] rt, ex;
            string      rtag;
            {lg, c, rt, lv, ex} = VEC[e];
            rtag = lg ? "R2 legacy route" : "R1 configured route";
            legacy_en = lg;
            ch_route[int'(c)*5 +: 5] = rt;
            ch_level[c] = lv;
            step();
            ch_fire[c] = 1'b1;
            step();
            ch_fire = '0;
            chk(rtag, {32'd0, irq_out}, 64'd1 << ex);
            chk(lv ? "R3 status set" : "R4 status stays clear", {63'd0, sts_rdata[c]}, {63'd0, lv});
            step();
            chk(lv ? "R3 level held" : "R4 pulse one clock", {32'd0, irq_out}, lv ? (64'd1 << ex) : 64'd0);
            if (lv) begin
                sts_wr = 1'b1;
                sts_wdata = 4'b1 << c;
                step();
                sts_wr = 1'b0;
                sts_wdata = '0;
                chk("R5 cleared", {28'd0, sts_rdata, irq_out}, 64'd0);
            end
        end

        // R5: selective clear
        legacy_en = 1'b0;
        ch_level = '1;
        ch_route = {5'd4, 5'd9, 5'd10, 5'd3};
        ch_fire = 4'b1001;
        step();
        ch_fire = '0;
        sts_wr = 1'b1;
        sts_wdata = 4'b0011;
        step();
        sts_wr = 1'b0;
        sts_wdata = '0;
        chk("R5 only written bits", {60'd0, sts_rdata}, 64'h8);
        chk("R5 other line kept", {32'd0, irq_out}, 64'd1 << 4);

        // R6: channel and global disable
        ch_en[3] = 1'b0;
        step();
        chk("R6 channel disable", {28'd0, sts_rdata, irq_out}, 64'd0);
        ch_en[3] = 1'b1;
        ch_fire[0] = 1'b1;
        step();
        ch_fire = '0;
        glb_en = 1'b0;
        step();
        chk("R6 global disable", {28'd0, sts_rdata, irq_out}, 64'd0);
        glb_en = 1'b1;
        ch_en[2] = 1'b0;
        ch_fire[2] = 1'b1;
        step();
        ch_fire = '0;
        chk("R6 expiry ignored", {28'd0, sts_rdata, irq_out}, 64'd0);
        ch_en[2] = 1'b1;

        // R8: enabling message mode withdraws interrupt
        ch_fire[2] = 1'b1;
        step();
        ch_fire = '0;
        chk("R8 precondition", {60'd0, sts_rdata}, 64'h4);
        ch_msg_en[2] = 1'b1;
        step();
        chk("R8 withdrawn", {28'd0, sts_rdata, irq_out}, 64'd0);
        chk("R8 no message", {63'd0, msg_req}, 64'd0);

        // R7 / R9: message write and merge
        ch_msg_dest[2*64 +: 64] = {32'hFEE0_1000, 32'h0000_0041};
        ch_fire[2] = 1'b1;
        step();
        ch_fire = '0;
        chk("R7 request", {63'd0, msg_req}, 64'd1);
        chk("R7 address/data", {msg_addr, msg_data}, {32'hFEE0_1000, 32'h0000_0041});
        chk("R7 no line or status", {28'd0, sts_rdata, irq_out}, 64'd0);
        ch_fire[2] = 1'b1;
        step();
        ch_fire = '0;
        step();
        chk("R9 held without ack", {63'd0, msg_req}, 64'd1);
        msg_ack = 1'b1;
        step();
        msg_ack = 1'b0;
        chk("R9 merged single write", {63'd0, msg_req}, 64'd0);

        // R11: ordering
        ch_msg_en = 4'b1010;
        ch_msg_dest[1*64 +: 64] = {32'hA000_0001, 32'h0000_0011};
        ch_msg_dest[3*64 +: 64] = {32'hA000_0003, 32'h0000_0033};
        step();
        ch_fire = 4'b1010;
        step();
        ch_fire = '0;
        chk("R11 lowest first", {msg_addr, msg_data}, {32'hA000_0001, 32'h0000_0011});
        msg_ack = 1'b1;
        step();
        msg_ack = 1'b0;
        chk("R11 next request", {63'd0, msg_req}, 64'd1);
        chk("R11 next channel", {msg_addr, msg_data}, {32'hA000_0003, 32'h0000_0033});
        msg_ack = 1'b1;
        step();
        msg_ack = 1'b0;
        chk("R11 all retired", {63'd0, msg_req}, 64'd0);

        // R10: external clock interrupt passthrough
        ch_msg_en = '0;
        rtc_irq_in = 1'b1;
        step();
        chk("R10 passthrough", {32'd0, irq_out}, 64'd1 << 8);
        legacy_en = 1'b1;
        step();
        chk("R10 gated in legacy", {32'd0, irq_out}, 64'd0);
        legacy_en = 1'b0;
        step();
        chk("R10 restored", {32'd0, irq_out}, 64'd1 << 8);
        rtc_irq_in = 1'b0;
        step();
        chk("R10 follows low", {32'd0, irq_out}, 64'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule